// File: doc/BRIEF.md
# Multi-Bit Trace Monitor with Masked Pattern Trigger

The block watches a parallel data bus and turns what it sees into trace elements on a valid/ready output stream. Its width `ELEM_W` is fixed at elaboration and may be 8, 32 or 64 bits; any other value stops elaboration. While running, the block either emits every sample or, in change-only mode, emits a sample only when it differs from the one taken on the previous clock. The first sample after the block starts running is always emitted.

A masked comparator checks each sample against a stored pattern. The trigger output pulses for one clock when a match begins. Three independent enables decide when an element is marked for a timestamp: on a pattern match, on a trigger, or always. A plain write port loads the configuration. The output has a single holding slot. If a new element finds that slot still occupied, the new element is dropped and a sticky overflow flag is set.

Top module: `mbit_trace_mon`

## Requirements
- R1: While `rst` is high, at the next rising edge `elem_valid`, `trig_pulse` and `overflow` become 0, all configuration bits become 0 and the pattern value and mask become 0.
- R2: Control register (address 0): bit 0 is run and bit 1 is change-only mode. With run=1 and mode=0, a sample on `smp_in` at a rising edge becomes an element on `elem_data` with `elem_valid`=1 after that edge, provided the holding slot is empty or `elem_ready` is 1 at that edge.
- R3: With run=1 and mode=1, a sample is emitted only if it differs from the sample taken at the previous edge. The first sample taken after run goes from 0 to 1 is always emitted. The previous-sample register is cleared by reset.
- R4: A sample matches when `((smp ^ value) & mask) == 0` over `ELEM_W` bits. Both value and mask are 64 bits wide. The value is written through address 1 (bits 31:0) and address 2 (bits 63:32). The mask is written through address 3 (bits 31:0) and address 4 (bits 63:32). Matching is gated by run.
- R5: `trig_pulse` is 1 for exactly one clock, after the edge at which a sample first matches. It stays 0 while later consecutive samples keep matching, and it can fire again only after a sample that does not match.
- R6: Control bit 2 set: an element whose sample matched is loaded with `elem_ts`=1.
- R7: Control bit 3 set: the element whose sample fired the trigger is loaded with `elem_ts`=1.
- R8: Control bit 4 set: every loaded element carries `elem_ts`=1. With bits 2 to 4 all clear, `elem_ts` is 0.
- R9: While `elem_valid`=1 and `elem_ready`=0, `elem_valid`, `elem_data` and `elem_ts` hold their values at the next edge.
- R10: An element that is due while the slot is occupied and `elem_ready`=0 is dropped, and `overflow` becomes 1 and stays 1. Writing control bit 5 as 1 clears it; if a drop happens on the same edge, the drop wins.
- R11: While run is 1, writes to the mode bit or to addresses 1 to 4 are ignored. The run bit and the timestamp bits stay writable at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | ELEM_W | Monitored data bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| elem_ready | input | 1 | Downstream accepts the element |
| elem_valid | output | 1 | Element pending |
| elem_data | output | ELEM_W | Element value |
| elem_ts | output | 1 | Element requests a timestamp |
| trig_pulse | output | 1 | One-clock trigger pulse |
| overflow | output | 1 | Sticky element-lost flag |

## Verification
A sample presented before rising edge k shows its element, timestamp flag and trigger pulse right after edge k, one register away. A configuration write at edge k first affects the sample taken at edge k+1, except for the overflow clear, which acts at edge k itself. The bench drives every input at the falling edge and updates a behavioural prediction for the coming rising edge. It then compares all outputs at the following falling edge, so each check lands exactly one register after its stimulus.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PATT_W = 64;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 3;

    // register select values
    localparam logic [ADDR_W-1:0] REG_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] REG_PAT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] REG_PAT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] REG_MSK_LO = 3'd3;
    localparam logic [ADDR_W-1:0] REG_MSK_HI = 3'd4;

    // control word bit positions
    localparam int B_RUN  = 0;
    localparam int B_CHG  = 1;
    localparam int B_PTS  = 2;
    localparam int B_TTS  = 3;
    localparam int B_ATS  = 4;
    localparam int B_OCLR = 5;

    typedef struct packed {
        logic run;
        logic on_change;
        logic pat_ts;
        logic trig_ts;
        logic all_ts;
    } ctrl_t;

    typedef struct packed {
        logic [PATT_W-1:0] value;
        logic [PATT_W-1:0] mask;
    } patt_t;

    typedef struct packed {
        logic hit;
        logic fire;
    } match_t;

    function automatic bit width_ok(int w);
        return (w == 8) || (w == 32) || (w == 64);
    endfunction

    function automatic logic ts_request(ctrl_t c, match_t m);
        return c.all_ts | (c.pat_ts & m.hit) | (c.trig_ts & m.fire);
    endfunction

    function automatic logic [PATT_W-1:0] put_word(logic [PATT_W-1:0] old,
                                                   logic [WORD_W-1:0] w,
                                                   logic upper);
        logic [PATT_W-1:0] r;
        r = old;
        if (upper) r[PATT_W-1:WORD_W] = w;
        else       r[WORD_W-1:0]      = w;
        return r;
    endfunction
endpackage

// File: rtl/mbt_cfg_regs.sv
module mbt_cfg_regs
    import mbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output ctrl_t             ctrl,
    output patt_t             patt,
    output logic              ovf_clr
);
    timeunit 1ns;
    timeprecision 1ps;

    logic locked;
    assign locked  = ctrl.run;
    assign ovf_clr = we && (addr == REG_CTRL) && wdata[B_OCLR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            patt <= '0;
        end else if (we) begin
            case (addr)
                REG_CTRL: begin
                    ctrl.run     <= wdata[B_RUN];
                    ctrl.pat_ts  <= wdata[B_PTS];
                    ctrl.trig_ts <= wdata[B_TTS];
                    ctrl.all_ts  <= wdata[B_ATS];
                    if (!locked) ctrl.on_change <= wdata[B_CHG];
                end
                REG_PAT_LO: if (!locked) patt.value <= put_word(patt.value, wdata, 1'b0);
                REG_PAT_HI: if (!locked) patt.value <= put_word(patt.value, wdata, 1'b1);
                REG_MSK_LO: if (!locked) patt.mask  <= put_word(patt.mask,  wdata, 1'b0);
                REG_MSK_HI: if (!locked) patt.mask  <= put_word(patt.mask,  wdata, 1'b1);
                default: ;
            endcase
        end
    end

    // R11
    locked_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.run |=> ($stable(patt) && $stable(ctrl.on_change)));
endmodule

// File: rtl/mbt_pattern.sv
module mbt_pattern
    import mbt_pkg::*;
#(
    parameter int ELEM_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  patt_t             patt,
    input  logic [ELEM_W-1:0] smp,
    output match_t            ev,
    output logic              trig_pulse
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LANE_W = 8;
    localparam int LANES  = ELEM_W / LANE_W;

    logic [LANES-1:0] lane_ok;
    logic             hit_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = g * LANE_W;
        assign lane_ok[g] =
            ((smp[LO +: LANE_W] ^ patt.value[LO +: LANE_W]) & patt.mask[LO +: LANE_W]) == '0;
    end

    assign ev.hit  = ctrl.run && (&lane_ok);
    assign ev.fire = ev.hit && !hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q      <= 1'b0;
            trig_pulse <= 1'b0;
        end else begin
            hit_q      <= ev.hit;
            trig_pulse <= ev.fire;
        end
    end

    // R5
    trig_single_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);

    // R5
    trig_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> !trig_pulse);
endmodule

// File: rtl/mbt_emit.sv
module mbt_emit
    import mbt_pkg::*;
#(
    parameter int ELEM_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [ELEM_W-1:0] smp,
    input  match_t            ev,
    input  logic              ovf_clr,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ELEM_W-1:0] out_data,
    output logic              out_ts,
    output logic              overflow
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [ELEM_W-1:0] prev_q;
    logic              first_q;
    logic              want, room, load, lost;

    assign want = ctrl.run && (!ctrl.on_change || first_q || (smp != prev_q));
    assign room = !out_valid || out_ready;
    assign load = want && room;
    assign lost = want && !room;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= '0;
            first_q   <= 1'b1;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ts    <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            first_q <= !ctrl.run;
            if (ctrl.run) prev_q <= smp;
            if (load) begin
                out_valid <= 1'b1;
                out_data  <= smp;
                out_ts    <= ts_request(ctrl, ev);
            end else if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (lost)         overflow <= 1'b1;
            else if (ovf_clr) overflow <= 1'b0;
        end
    end

    // R9
    hold_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ts)));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ovf_clr) |=> overflow);

    // R10
    ovf_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && want) |=> overflow);

    // R3
    no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && ctrl.on_change && !first_q && (smp == prev_q) && (!out_valid || out_ready))
        |=> !out_valid);

    // R2
    cont_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && !ctrl.on_change && (!out_valid || out_ready))
        |=> (out_valid && out_data == $past(smp)));

    // R8
    ts_all_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.all_ts && want && (!out_valid || out_ready)) |=> (out_valid && out_ts));
endmodule

// File: rtl/mbit_trace_mon.sv
module mbit_trace_mon
    import mbt_pkg::*;
#(
    parameter int ELEM_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ELEM_W-1:0] smp_in,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              elem_ready,
    output logic              elem_valid,
    output logic [ELEM_W-1:0] elem_data,
    output logic              elem_ts,
    output logic              trig_pulse,
    output logic              overflow
);
    timeunit 1ns;
    timeprecision 1ps;

    if (!width_ok(ELEM_W)) begin : g_bad_width
        $error("ELEM_W must be 8, 32 or 64");
    end

    ctrl_t  ctrl;
    patt_t  patt;
    match_t ev;
    logic   ovf_clr;

    mbt_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .ctrl    (ctrl),
        .patt    (patt),
        .ovf_clr (ovf_clr)
    );

    mbt_pattern #(.ELEM_W(ELEM_W)) u_pat (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .patt       (patt),
        .smp        (smp_in),
        .ev         (ev),
        .trig_pulse (trig_pulse)
    );

    mbt_emit #(.ELEM_W(ELEM_W)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .smp       (smp_in),
        .ev        (ev),
        .ovf_clr   (ovf_clr),
        .out_ready (elem_ready),
        .out_valid (elem_valid),
        .out_data  (elem_data),
        .out_ts    (elem_ts),
        .overflow  (overflow)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!elem_valid && !trig_pulse && !overflow));
endmodule

// File: tb/mbit_trace_mon_test.sv
module mbit_trace_mon_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] smp = '0;
    logic         we = 1'b0;
    logic [2:0]   addr = '0;
    logic [31:0]  wd = '0;
    logic         rdy = 1'b0;
    logic         ev, ets, trg, ovf;
    logic [W-1:0] ed;

    mbit_trace_mon #(.ELEM_W(W)) uut (
        .clk(clk), .rst(rst), .smp_in(smp), .cfg_we(we), .cfg_addr(addr),
        .cfg_wdata(wd), .elem_ready(rdy), .elem_valid(ev), .elem_data(ed),
        .elem_ts(ets), .trig_pulse(trg), .overflow(ovf)
    );

    always #2 clk = ~clk;  // 250 MHz

    // prediction state
    bit m_run, m_chg, m_pts, m_tts, m_ats;
    logic [63:0] m_pat = '0, m_msk = '0, m_d = '0, m_prev = '0;
    bit m_v, m_t, m_trig, m_ovf, m_hprev;
    bit m_first = 1'b1;

    int errs = 0, checks = 0;
    string tag;
    bit done = 1'b0;

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void predict(logic [63:0] s, bit r, bit w, logic [2:0] a, logic [31:0] d);
        bit hit, fire, emit, tsr;
        hit  = m_run && (((s ^ m_pat) & m_msk) == 64'd0);
        fire = hit && !m_hprev;
        emit = m_run && (!m_chg || m_first || (s != m_prev));
        tsr  = m_ats | (m_pts & hit) | (m_tts & fire);
        if (w && a == 3'd0 && d[5]) m_ovf = 1'b0;
        if (emit) begin
            if (!m_v || r) begin m_v = 1'b1; m_d = s; m_t = tsr; end
            else m_ovf = 1'b1;
        end else if (m_v && r) m_v = 1'b0;
        m_trig  = fire;
        m_hprev = hit;
        if (m_run) m_prev = s;
        m_first = !m_run;
        if (w) begin
            case (a)
                3'd0: begin
                    if (!m_run) m_chg = d[1];
                    m_run = d[0]; m_pts = d[2]; m_tts = d[3]; m_ats = d[4];
                end
                3'd1: if (!m_run) m_pat[31:0]  = d;
                3'd2: if (!m_run) m_pat[63:32] = d;
                3'd3: if (!m_run) m_msk[31:0]  = d;
                3'd4: if (!m_run) m_msk[63:32] = d;
                default: ;
            endcase
        end
    endfunction

    task automatic cyc(logic [63:0] s, bit r, bit w, logic [2:0] a, logic [31:0] d);
        smp = s; rdy = r; we = w; addr = a; wd = d;
        predict(s, r, w, a, d);
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
        chk("valid", ev, m_v);
        chk("trigger", trg, m_trig);
        chk("overflow", ovf, m_ovf);
        if (m_v) begin
            chk("data", ed, m_d);
            chk("timestamp", ets, m_t);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        cyc(smp, 1'b1, 1'b1, a, d);
    endtask

    localparam logic [63:0] HIT_A = 64'h1234_5678_9ABC_DEA5;
    localparam logic [63:0] HIT_B = 64'h1234_0000_0000_11A5; // differs only in unmasked bits
    localparam logic [63:0] MISS  = 64'h1235_5678_9ABC_DEA5;

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("valid", ev, 1'b0);
        chk("trigger", trg, 1'b0);
        chk("overflow", ovf, 1'b0);
        rst = 1'b0;

        tag = "R4";
        wr(3'd1, 32'h0000_00A5);
        wr(3'd2, 32'h1234_0000);
        wr(3'd3, 32'h0000_00FF);
        wr(3'd4, 32'hFFFF_0000);

        tag = "R2";
        wr(3'd0, 32'h1);
        for (int i = 0; i < 6; i++) cyc(64'(i * 3 + 1), 1'b1, 1'b0, 3'd0, '0);
        cyc(64'd7, 1'b1, 1'b0, 3'd0, '0);
        cyc(64'd7, 1'b1, 1'b0, 3'd0, '0);

        tag = "R4 R5";
        cyc(HIT_A, 1'b1, 1'b0, 3'd0, '0);
        cyc(HIT_B, 1'b1, 1'b0, 3'd0, '0);
        cyc(HIT_A, 1'b1, 1'b0, 3'd0, '0);
        cyc(MISS,  1'b1, 1'b0, 3'd0, '0);
        cyc(HIT_B, 1'b1, 1'b0, 3'd0, '0);
        cyc(64'd0, 1'b1, 1'b0, 3'd0, '0);

        tag = "R6";
        wr(3'd0, 32'h5);
        cyc(HIT_A, 1'b1, 1'b0, 3'd0, '0);
        cyc(HIT_A, 1'b1, 1'b0, 3'd0, '0);
        cyc(MISS,  1'b1, 1'b0, 3'd0, '0);

        tag = "R7";
        wr(3'd0, 32'h9);
        cyc(HIT_B, 1'b1, 1'b0, 3'd0, '0);
        cyc(HIT_A, 1'b1, 1'b0, 3'd0, '0);
        cyc(MISS,  1'b1, 1'b0, 3'd0, '0);

        tag = "R8";
        wr(3'd0, 32'h11);
        cyc(MISS, 1'b1, 1'b0, 3'd0, '0);
        cyc(64'd5, 1'b1, 1'b0, 3'd0, '0);
        wr(3'd0, 32'h1);
        cyc(HIT_A, 1'b1, 1'b0, 3'd0, '0);

        tag = "R11";
        wr(3'd1, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h3);
        cyc(64'd9, 1'b1, 1'b0, 3'd0, '0);
        cyc(64'd9, 1'b1, 1'b0, 3'd0, '0);
        cyc(64'd9, 1'b1, 1'b0, 3'd0, '0);
        cyc(HIT_A, 1'b1, 1'b0, 3'd0, '0);
        cyc(HIT_B, 1'b1, 1'b0, 3'd0, '0);

        tag = "R3";
        wr(3'd0, 32'h0);
        wr(3'd0, 32'h2);
        wr(3'd0, 32'h3);
        cyc(m_prev, 1'b1, 1'b0, 3'd0, '0);   // first sample, equal to previous
        cyc(m_prev, 1'b1, 1'b0, 3'd0, '0);
        cyc(m_prev, 1'b1, 1'b0, 3'd0, '0);
        cyc(64'hAB, 1'b1, 1'b0, 3'd0, '0);
        cyc(64'hAB, 1'b1, 1'b0, 3'd0, '0);
        cyc(64'hAC, 1'b1, 1'b0, 3'd0, '0);

        tag = "R9";
        wr(3'd0, 32'h0);
        wr(3'd0, 32'h1);
        cyc(64'h11, 1'b0, 1'b0, 3'd0, '0);
        cyc(64'h22, 1'b0, 1'b0, 3'd0, '0);
        cyc(64'h33, 1'b0, 1'b0, 3'd0, '0);
        tag = "R10";
        cyc(64'h44, 1'b1, 1'b0, 3'd0, '0);
        cyc(64'h55, 1'b1, 1'b0, 3'd0, '0);
        wr(3'd0, 32'h21);
        cyc(64'h66, 1'b1, 1'b0, 3'd0, '0);
        cyc(64'h77, 1'b0, 1'b0, 3'd0, '0);
        cyc(64'h88, 1'b0, 1'b1, 3'd0, 32'h21);  // drop and clear together: drop wins

        tag = "random R2 R3 R5 R6 R7 R8 R9 R10 R11";
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h2); wr(3'd2, 32'h1); wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF);
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] s;
            logic [2:0]  a;
            logic [31:0] d;
            bit w;
            s = {32'($urandom % 3), 32'($urandom % 3)};
            w = ($urandom % 40) == 0;
            a = 3'($urandom % 6);
            if (a == 3'd0) d = ($urandom & 32'h3E) | 32'(($urandom % 5) != 0);
            else if (a == 3'd1 || a == 3'd2) d = $urandom % 3;
            else d = (($urandom % 2) == 0) ? 32'hFFFF_FFFF : 32'h3;
            cyc(s, ($urandom % 4) != 0, w, a, d);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule